// File: doc/BRIEF.md
# Instruction Cycle Control Sequencer

This block is the multicycle control unit of a small processor. It walks one instruction at a time through a fixed order of steps. It computes the instruction address and fetches the word. It then decodes and, for each operand, computes the operand address and fetches the operand. After one cycle of data operation it computes the address of each result and writes the result. At the end it checks for an interrupt. The block owns the program counter, the instruction register, the memory address register and the memory buffer register. It reaches memory through a single port with request/ready handshaking. Memory addresses always come from the address register and write data always comes from the buffer register.

An outside decoder looks at the `ir` output and returns three hints: whether operand and result addresses are indirect, how many operands there are, and how many results there are. The sequencer samples them in its decode cycle. The data operation is a placeholder: it combines the fetched operands with XOR. When an interrupt is enabled and pending at the end of an instruction, the sequencer writes the program counter to a fixed save location and continues at a fixed handler address.

Top module: `instr_cycle_seq`

## Requirements
- R1: A fetch loads the address register from the program counter and reads memory into the buffer register. The next cycle copies the buffer into `ir` and pulses `ld_ir`. The program counter rises by one when the fetch read completes.
- R2: With zero memory wait, an instruction with no operands and no results takes 6 cycles from one `ld_ir` pulse to the next. Each operand adds 2 cycles, each result adds 2, and indirection adds 2 more per operand or result address.
- R3: Every memory access holds `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` steady until `mem_ready`. Each wait cycle lengthens the instruction by exactly one cycle.
- R4: When `dec_indirect` is 1, the word read at each computed operand or result address is used as a pointer. Its low address bits give the effective address.
- R5: Operand i (i = 0 to N-1, N = `dec_num_ops`) is read from the base address `ir[AW-1:0]` + i. With N = 0, no operand is read.
- R6: Result j (j = 0 to M-1, M = `dec_num_res`) is written at base + N + j. The value written is the XOR of all operands fetched by the instruction (0 when there are none). With M = 0, nothing is written.
- R7: If `irq` and `irq_en` are both 1 at the end of an instruction, the program counter is written to SAVE_ADDR, the next fetch uses HANDLER_ADDR, and `irq_en` drops to 0.
- R8: While `irq_en` is 0, `irq` has no effect: the save location is not written and fetching continues in sequence. A pulse on `irq_en_set` sets `irq_en`.
- R9: A synchronous active-low reset puts the sequencer in the fetch-address step (`ld_mar` high, `mem_req` low), the program counter at 0 and `irq_en` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Access address (address register) |
| mem_wdata | output | DW | Write data (buffer register) |
| mem_rdata | input | DW | Read data |
| mem_ready | input | 1 | Access completes this cycle |
| ir | output | DW | Instruction register, to the decoder |
| pc | output | AW | Program counter |
| dec_indirect | input | 1 | Operand/result addresses are pointers |
| dec_num_ops | input | CW | Number of operands |
| dec_num_res | input | CW | Number of results |
| irq | input | 1 | Interrupt request level |
| irq_en_set | input | 1 | Pulse that sets the interrupt enable |
| irq_en | output | 1 | Interrupt enable flag |
| ld_pc | output | 1 | Program counter load strobe |
| ld_ir | output | 1 | Instruction register load strobe |
| ld_mar | output | 1 | Address register load strobe |
| ld_mbr | output | 1 | Buffer register load strobe |

## Verification
The bench times each instruction from one `ld_ir` pulse to the next. A sequencer that skipped the pointer read or the return to address calculation, or that ran one loop pass too many or too few, would miss the exact cycle count. It would also put the combined result at the wrong place. Mixed wait states show whether a step moves on before `mem_ready`; a design that did so would read stale data and finish early. The bench tests interrupts three ways: a request while disabled, the taken case, and a request still held inside the handler. Each case catches a design that saves the wrong counter value, re-enters the handler, or lets a disabled request through.

// File: rtl/ics_pkg.sv
// Package: shared encodings for the instruction cycle sequencer.
// Assumes: one step per enum value; the source selects are decoded by ics_regs.
package ics_pkg;

    typedef enum logic [3:0] {
        S_FADDR,   // instruction address into MAR
        S_FMEM,    // instruction read into MBR
        S_FIR,     // MBR into IR
        S_DEC,     // sample decoder hints
        S_OADDR,   // operand address calculation
        S_IREAD,   // pointer read (indirect)
        S_ILOAD,   // pointer into MAR
        S_OREAD,   // operand read
        S_EXEC,    // data operation
        S_RADDR,   // result address calculation
        S_RWRITE,  // result write
        S_ICHK,    // interrupt check
        S_ISAVE    // program counter save
    } step_e;

    typedef enum logic [1:0] {MAR_PC, MAR_EA, MAR_PTR, MAR_SAVE} mar_src_e;
    typedef enum logic [1:0] {MBR_MEM, MBR_ACC, MBR_PC}          mbr_src_e;

endpackage

// File: rtl/ics_ctrl.sv
// Module: step sequencer of the instruction cycle.
// Holds the current step, the operand/result loop index and the latched
// decoder hints, and emits register-load strobes and memory requests.
// Assumes: mem_ready is only meaningful while mem_req is high.
module ics_ctrl
    import ics_pkg::*;
#(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mem_ready,
    input  logic          dec_indirect,
    input  logic [CW-1:0] dec_num_ops,
    input  logic [CW-1:0] dec_num_res,
    input  logic          irq,
    input  logic          irq_en_set,
    output logic          mem_req,
    output logic          mem_we,
    output logic          ld_pc,
    output logic          pc_to_handler,
    output logic          ld_ir,
    output logic          ld_mar,
    output logic          ld_mbr,
    output mar_src_e      mar_src,
    output mbr_src_e      mbr_src,
    output logic          acc_clr,
    output logic          acc_en,
    output logic [CW:0]   addr_off,
    output logic          irq_en
);

    step_e         st, st_nxt;
    logic [CW-1:0] idx;
    logic [CW-1:0] nops_q, nres_q;
    logic          ind_q;
    logic          res_ph;
    logic          last_op, last_res, take_irq;

    assign last_op  = ({1'b0, idx} + 1'b1) == {1'b0, nops_q};
    assign last_res = ({1'b0, idx} + 1'b1) == {1'b0, nres_q};
    assign take_irq = (st == S_ICHK) && irq && irq_en;

    // Next step and strobes for the current step.
    always_comb begin
        st_nxt        = st;
        mem_req       = 1'b0;
        mem_we        = 1'b0;
        ld_pc         = 1'b0;
        pc_to_handler = 1'b0;
        ld_ir         = 1'b0;
        ld_mar        = 1'b0;
        ld_mbr        = 1'b0;
        mar_src       = MAR_PC;
        mbr_src       = MBR_MEM;
        acc_clr       = 1'b0;
        acc_en        = 1'b0;
        addr_off      = {1'b0, idx};
        unique case (st)
            S_FADDR: begin
                ld_mar = 1'b1;
                st_nxt = S_FMEM;
            end
            S_FMEM: begin
                mem_req = 1'b1;
                if (mem_ready) begin
                    ld_mbr = 1'b1;
                    ld_pc  = 1'b1;
                    st_nxt = S_FIR;
                end
            end
            S_FIR: begin
                ld_ir  = 1'b1;
                st_nxt = S_DEC;
            end
            S_DEC: begin
                acc_clr = 1'b1;
                st_nxt  = (dec_num_ops != '0) ? S_OADDR : S_EXEC;
            end
            S_OADDR: begin
                ld_mar  = 1'b1;
                mar_src = MAR_EA;
                st_nxt  = ind_q ? S_IREAD : S_OREAD;
            end
            S_IREAD: begin
                mem_req = 1'b1;
                if (mem_ready) begin
                    ld_mbr = 1'b1;
                    st_nxt = S_ILOAD;
                end
            end
            S_ILOAD: begin
                ld_mar  = 1'b1;
                mar_src = MAR_PTR;
                if (res_ph) begin
                    ld_mbr  = 1'b1;
                    mbr_src = MBR_ACC;
                    st_nxt  = S_RWRITE;
                end else begin
                    st_nxt  = S_OREAD;
                end
            end
            S_OREAD: begin
                mem_req = 1'b1;
                if (mem_ready) begin
                    ld_mbr = 1'b1;
                    acc_en = 1'b1;
                    st_nxt = last_op ? S_EXEC : S_OADDR;
                end
            end
            S_EXEC: begin
                st_nxt = (nres_q != '0) ? S_RADDR : S_ICHK;
            end
            S_RADDR: begin
                ld_mar   = 1'b1;
                mar_src  = MAR_EA;
                addr_off = {1'b0, nops_q} + {1'b0, idx};
                if (ind_q) begin
                    st_nxt  = S_IREAD;
                end else begin
                    ld_mbr  = 1'b1;
                    mbr_src = MBR_ACC;
                    st_nxt  = S_RWRITE;
                end
            end
            S_RWRITE: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                if (mem_ready) st_nxt = last_res ? S_ICHK : S_RADDR;
            end
            S_ICHK: begin
                if (take_irq) begin
                    ld_mar  = 1'b1;
                    mar_src = MAR_SAVE;
                    ld_mbr  = 1'b1;
                    mbr_src = MBR_PC;
                    st_nxt  = S_ISAVE;
                end else begin
                    st_nxt  = S_FADDR;
                end
            end
            S_ISAVE: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                if (mem_ready) begin
                    ld_pc         = 1'b1;
                    pc_to_handler = 1'b1;
                    st_nxt        = S_FADDR;
                end
            end
            default: st_nxt = S_FADDR;
        endcase
    end

    // Step register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= S_FADDR;
        else        st <= st_nxt;
    end

    // Loop index, phase flag and latched decoder hints.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx    <= '0;
            res_ph <= 1'b0;
            ind_q  <= 1'b0;
            nops_q <= '0;
            nres_q <= '0;
        end else begin
            if (st == S_DEC) begin
                idx    <= '0;
                res_ph <= 1'b0;
                ind_q  <= dec_indirect;
                nops_q <= dec_num_ops;
                nres_q <= dec_num_res;
            end else if (st == S_EXEC) begin
                idx    <= '0;
                res_ph <= 1'b1;
            end else if ((st == S_OREAD || st == S_RWRITE) && mem_ready) begin
                idx    <= idx + 1'b1;
            end
        end
    end

    // Interrupt enable: a taken interrupt wins over a set pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)          irq_en <= 1'b0;
        else if (take_irq)   irq_en <= 1'b0;
        else if (irq_en_set) irq_en <= 1'b1;
    end

endmodule

// File: rtl/ics_regs.sv
// Module: architectural registers PC, IR, MAR, MBR plus the operand combiner.
// Loads each register on its strobe from the source picked by the sequencer.
// Assumes: DW > AW, and the base address is the low AW bits of IR.
module ics_regs
    import ics_pkg::*;
#(
    parameter int          AW           = 8,
    parameter int          DW           = 16,
    parameter int          CW           = 3,
    parameter logic [AW-1:0] HANDLER_ADDR = '0,
    parameter logic [AW-1:0] SAVE_ADDR    = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] mem_rdata,
    input  logic          ld_pc,
    input  logic          pc_to_handler,
    input  logic          ld_ir,
    input  logic          ld_mar,
    input  logic          ld_mbr,
    input  mar_src_e      mar_src,
    input  mbr_src_e      mbr_src,
    input  logic          acc_clr,
    input  logic          acc_en,
    input  logic [CW:0]   addr_off,
    output logic [AW-1:0] pc,
    output logic [DW-1:0] ir,
    output logic [AW-1:0] mar,
    output logic [DW-1:0] mbr
);

    logic [DW-1:0] acc;
    logic [AW-1:0] ea;
    logic [AW-1:0] mar_d;
    logic [DW-1:0] mbr_d;

    assign ea = ir[AW-1:0] + AW'(addr_off);

    // Source selection for MAR and MBR.
    always_comb begin
        unique case (mar_src)
            MAR_PC:   mar_d = pc;
            MAR_EA:   mar_d = ea;
            MAR_PTR:  mar_d = mbr[AW-1:0];
            default:  mar_d = SAVE_ADDR;
        endcase
        unique case (mbr_src)
            MBR_MEM:  mbr_d = mem_rdata;
            MBR_ACC:  mbr_d = acc;
            default:  mbr_d = DW'(pc);
        endcase
    end

    // Register file updates on the strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc  <= '0;
            ir  <= '0;
            mar <= '0;
            mbr <= '0;
            acc <= '0;
        end else begin
            if (ld_pc)   pc  <= pc_to_handler ? HANDLER_ADDR : pc + 1'b1;
            if (ld_ir)   ir  <= mbr;
            if (ld_mar)  mar <= mar_d;
            if (ld_mbr)  mbr <= mbr_d;
            if (acc_clr)     acc <= '0;
            else if (acc_en) acc <= acc ^ mem_rdata;
        end
    end

endmodule

// File: rtl/instr_cycle_seq.sv
// Module: top of the instruction cycle sequencer.
// Joins the step sequencer to the register set; memory address and write
// data come straight from MAR and MBR.
// Assumes: one memory port, decoder hints valid while ir is stable.
module instr_cycle_seq
    import ics_pkg::*;
#(
    parameter int            AW           = 8,
    parameter int            DW           = 16,
    parameter int            CW           = 3,
    parameter logic [AW-1:0] HANDLER_ADDR = 8'h30,
    parameter logic [AW-1:0] SAVE_ADDR    = 8'h3F
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ready,
    output logic [DW-1:0] ir,
    output logic [AW-1:0] pc,
    input  logic          dec_indirect,
    input  logic [CW-1:0] dec_num_ops,
    input  logic [CW-1:0] dec_num_res,
    input  logic          irq,
    input  logic          irq_en_set,
    output logic          irq_en,
    output logic          ld_pc,
    output logic          ld_ir,
    output logic          ld_mar,
    output logic          ld_mbr
);

    mar_src_e    mar_src;
    mbr_src_e    mbr_src;
    logic        pc_to_handler;
    logic        acc_clr, acc_en;
    logic [CW:0] addr_off;

    ics_ctrl #(.CW(CW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .mem_ready(mem_ready),
        .dec_indirect(dec_indirect), .dec_num_ops(dec_num_ops),
        .dec_num_res(dec_num_res), .irq(irq), .irq_en_set(irq_en_set),
        .mem_req(mem_req), .mem_we(mem_we), .ld_pc(ld_pc),
        .pc_to_handler(pc_to_handler), .ld_ir(ld_ir), .ld_mar(ld_mar),
        .ld_mbr(ld_mbr), .mar_src(mar_src), .mbr_src(mbr_src),
        .acc_clr(acc_clr), .acc_en(acc_en), .addr_off(addr_off),
        .irq_en(irq_en)
    );

    ics_regs #(
        .AW(AW), .DW(DW), .CW(CW),
        .HANDLER_ADDR(HANDLER_ADDR), .SAVE_ADDR(SAVE_ADDR)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .mem_rdata(mem_rdata),
        .ld_pc(ld_pc), .pc_to_handler(pc_to_handler), .ld_ir(ld_ir),
        .ld_mar(ld_mar), .ld_mbr(ld_mbr), .mar_src(mar_src),
        .mbr_src(mbr_src), .acc_clr(acc_clr), .acc_en(acc_en),
        .addr_off(addr_off), .pc(pc), .ir(ir), .mar(mem_addr),
        .mbr(mem_wdata)
    );

endmodule

// File: rtl/ics_checker.sv
// Module: temporal checks on the sequencer's ports, bound to the top.
// Assumes: the save location is only written by an interrupt entry.
module ics_checker #(
    parameter int            AW        = 8,
    parameter int            DW        = 16,
    parameter logic [AW-1:0] SAVE_ADDR = '0
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_req,
    input logic          mem_we,
    input logic          mem_ready,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_wdata,
    input logic [AW-1:0] pc,
    input logic          irq_en,
    input logic          ld_ir,
    input logic          ld_mbr
);

    logic seen_rst = 1'b0;

    // Marks that a reset edge has been seen.
    always_ff @(posedge clk) begin
        if (!rst_n) seen_rst <= 1'b1;
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R3

    AST_IR_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        ld_ir |-> $past(ld_mbr)); // R1

    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_ir && $past(rst_n)) |-> (pc == $past(pc) + 1'b1)); // R1

    AST_INT_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_en) |-> (mem_req && mem_we && mem_addr == SAVE_ADDR && mem_wdata == DW'(pc))); // R7

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (!seen_rst)
        $past(!rst_n) |-> (pc == '0 && !mem_req && !irq_en)); // R9

endmodule

bind instr_cycle_seq ics_checker #(.AW(AW), .DW(DW), .SAVE_ADDR(SAVE_ADDR)) u_ics_checker (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
    .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .pc(pc), .irq_en(irq_en), .ld_ir(ld_ir), .ld_mbr(ld_mbr)
);

// File: tb/tb_instr_cycle_seq.sv
`timescale 1ns/1ps
// Bench: memory model with programmable wait, decoder built from ir bits
// [15] indirect, [14:12] operand count, [11:9] result count, [7:0] base.
module tb_instr_cycle_seq;

    localparam int            AW      = 8;
    localparam int            DW      = 16;
    localparam int            CW      = 3;
    localparam logic [AW-1:0] HANDLER = 8'h30;
    localparam logic [AW-1:0] SAVE    = 8'h3F;
    localparam int            NVEC    = 6;
    // {wait cycles, instruction word}
    localparam logic [19:0] VEC [0:NVEC-1] = '{
        20'h00040, 20'h02250, 20'h29260, 20'h13470, 20'h0A480, 20'h30290
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mem_req, mem_we, mem_ready;
    logic [AW-1:0] mem_addr, pc;
    logic [DW-1:0] mem_wdata, mem_rdata, ir;
    logic          dec_indirect;
    logic [CW-1:0] dec_num_ops, dec_num_res;
    logic          irq = 1'b0, irq_en_set = 1'b0, irq_en;
    logic          ld_pc, ld_ir, ld_mar, ld_mbr;

    logic [DW-1:0] mem [0:255];
    int            wait_n = 0;
    int            wcnt = 0;
    int            n_chk = 0, n_fail = 0;
    bit            done = 1'b0;

    always #4 clk = ~clk;

    assign dec_indirect = ir[15];
    assign dec_num_ops  = ir[14:12];
    assign dec_num_res  = ir[11:9];
    assign mem_rdata    = mem[mem_addr];
    assign mem_ready    = mem_req && (wcnt == wait_n);

    // Memory model: wait counter and write port.
    always @(posedge clk) begin
        wcnt <= (mem_req && !mem_ready) ? wcnt + 1 : 0;
        if (mem_req && mem_we && mem_ready) mem[mem_addr] <= mem_wdata;
    end

    instr_cycle_seq #(.AW(AW), .DW(DW), .CW(CW), .HANDLER_ADDR(HANDLER), .SAVE_ADDR(SAVE)) dut (
        .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ready(mem_ready), .ir(ir), .pc(pc), .dec_indirect(dec_indirect),
        .dec_num_ops(dec_num_ops), .dec_num_res(dec_num_res), .irq(irq),
        .irq_en_set(irq_en_set), .irq_en(irq_en), .ld_pc(ld_pc),
        .ld_ir(ld_ir), .ld_mar(ld_mar), .ld_mbr(ld_mbr)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // Cycles from one ld_ir to the next, sampled on falling edges.
    task automatic to_next_ir(output int cyc, input logic [DW-1:0] word, input int exp_pc, input string tag);
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
            if (cyc == 1) begin
                chk(ir == word, {tag, " ir"}, int'(ir), int'(word));
                chk(pc == AW'(exp_pc), {tag, " pc"}, int'(pc), exp_pc);
            end
        end while (!ld_ir && cyc < 500);
    endtask

    function automatic int exp_cycles(input logic [DW-1:0] w, input int ws);
        int per;
        per = 2 + ws + (w[15] ? 2 + ws : 0);
        return 6 + ws + int'(w[14:12]) * per + int'(w[11:9]) * per;
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        finish_up();
    end

    initial begin
        int            cyc;
        logic [DW-1:0] x;
        logic [AW-1:0] a;
        logic [AW-1:0] raddr [0:7];
        int            nres;

        for (int i = 0; i < 256; i++) mem[i] = DW'(i * 16'h0123) ^ 16'h5A5A;
        for (int k = 0; k < NVEC; k++) mem[k] = VEC[k][15:0];
        mem[NVEC] = 16'h0000;
        mem[8'h60] = 16'h00C0; mem[8'h61] = 16'h00D0;
        mem[8'h80] = 16'h00C4; mem[8'h81] = 16'h00C5;
        mem[8'h82] = 16'h00D4; mem[8'h83] = 16'h00D5;
        mem[HANDLER] = 16'h0000; mem[HANDLER + 1] = 16'h0000;
        mem[SAVE] = 16'hDEAD;

        repeat (3) @(negedge clk);
        // R9: reset state
        chk(pc == 0 && !mem_req && !irq_en, "R9 reset pc/req/en", {pc, 7'd0, mem_req, irq_en}, 0);
        chk(ld_mar == 1'b1, "R9 fetch step after reset", int'(ld_mar), 1);
        rst_n = 1'b1;
        do @(negedge clk); while (!ld_ir);

        // Vector loop: R1 R2 R3 R4 R5 R6
        for (int k = 0; k < NVEC; k++) begin
            logic [DW-1:0] w;
            w      = VEC[k][15:0];
            wait_n = int'(VEC[k][19:16]);
            x = '0;
            for (int i = 0; i < int'(w[14:12]); i++) begin
                a = w[7:0] + AW'(i);
                if (w[15]) a = mem[a][AW-1:0];
                x ^= mem[a];
            end
            nres = int'(w[11:9]);
            for (int j = 0; j < nres; j++) begin
                a = w[7:0] + AW'(w[14:12]) + AW'(j);
                raddr[j] = w[15] ? mem[a][AW-1:0] : a;
            end
            to_next_ir(cyc, w, k + 1, "R1 fetch");
            chk(cyc == exp_cycles(w, wait_n), "R2 R3 cycle count", cyc, exp_cycles(w, wait_n));
            for (int j = 0; j < nres; j++)
                chk(mem[raddr[j]] == x, "R4 R5 R6 result value", int'(mem[raddr[j]]), int'(x));
        end

        // R9: reset clears an enabled interrupt flag
        @(negedge clk); irq_en_set = 1'b1; @(negedge clk); irq_en_set = 1'b0;
        chk(irq_en == 1'b1, "R8 enable set pulse", int'(irq_en), 1);
        rst_n = 1'b0; wait_n = 0;
        repeat (2) @(negedge clk);
        chk(pc == 0 && !irq_en && ld_mar, "R9 reset again", {pc, 6'd0, irq_en, ld_mar}, 1);
        irq = 1'b1;
        rst_n = 1'b1;
        do @(negedge clk); while (!ld_ir);

        // R8: request while disabled is ignored
        to_next_ir(cyc, VEC[0][15:0], 1, "R8 disabled");
        chk(cyc == 6, "R8 no extra save cycle", cyc, 6);
        chk(mem[SAVE] == 16'hDEAD, "R8 save slot untouched", int'(mem[SAVE]), 16'hDEAD);

        // R7: enable during instruction 1, interrupt taken at its end
        @(negedge clk); irq_en_set = 1'b1; @(negedge clk); irq_en_set = 1'b0;
        cyc = 2;
        do begin @(negedge clk); cyc++; end while (!ld_ir && cyc < 500);
        chk(cyc == exp_cycles(VEC[1][15:0], 0) + 1, "R7 save adds one cycle", cyc, exp_cycles(VEC[1][15:0], 0) + 1);
        chk(mem[SAVE] == 16'h0002, "R7 saved pc", int'(mem[SAVE]), 2);
        chk(irq_en == 1'b0, "R7 enable cleared", int'(irq_en), 0);
        mem[SAVE] = 16'hBEEF;
        to_next_ir(cyc, mem[HANDLER], int'(HANDLER) + 1, "R7 handler fetch");
        chk(cyc == 6, "R8 handler not re-entered", cyc, 6);
        chk(mem[SAVE] == 16'hBEEF, "R8 no second save", int'(mem[SAVE]), 16'hBEEF);
        chk(pc == HANDLER + 2, "R8 sequential after handler", int'(pc), int'(HANDLER) + 2);
        irq = 1'b0;

        finish_up();
    end

endmodule